// File: doc/BRIEF.md
# Ring Wake Event Status Logic

This block receives the already filtered, active-low ring indication and records each new ring event in two sticky status bits. One belongs to the soft-power wakeup group and is cleared when its register is read. The other belongs to the PME group, is cleared by writing a one to it, and also serves as the status source for the SMI path. Three enable bits each gate one destination, and the block drives three level requests: power-on, SMI and PME/SCI.

Software reaches the block through a small register port. It has an address, separate read and write strobes, 8-bit write data and registered 8-bit read data. The ring input is synchronised into the clock domain and its falling edge is taken as the event. A new event always survives a clear that lands in the same cycle, so a ring is never lost.

Top module: `ring_wake_status`

## Requirements
- R1: A falling edge on `ring_n_i` sets both status bits. This happens SYNC_STAGES+1 rising edges after the low level is first sampled. A level held low after a clear does not set them again, and neither does a rising edge.
- R2: Both status bits latch whether or not any enable bit is set.
- R3: The soft-power status is bit 3 at address 0. A read strobe at address 0 returns the current value on `reg_rdata_o` after the next rising edge and clears the bit at that edge.
- R4: The PME status is bit 5 at address 3. A write to address 3 with data bit 5 set clears it. A write with bit 5 clear leaves it unchanged. A read of address 3 does not clear it.
- R5: Writes to address 0 do not change the soft-power status.
- R6: The enable bits are writable and read back as follows: soft-power enable at address 1 bit 3, SMI enable at address 2 bit 0, PME enable at address 4 bit 5. All other bits of these registers read 0.
- R7: `pwr_on_req_o` equals (soft-power status AND soft-power enable) as of the previous rising edge.
- R8: `smi_req_o` equals (PME status AND SMI enable) as of the previous rising edge.
- R9: `pme_req_o` equals (PME status AND PME enable) as of the previous rising edge.
- R10: When a ring event and a clear (read of address 0, or write-one to address 3 bit 5) reach a status bit at the same edge, the bit ends set.
- R11: Synchronous reset clears all status bits, enables, requests and read data.
- R12: Addresses 5 to 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_n_i | input | 1 | Filtered ring indication, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| pwr_on_req_o | output | 1 | Power-on request |
| smi_req_o | output | 1 | SMI request |
| pme_req_o | output | 1 | PME/SCI request |

## Verification
The bench lines up a ring edge with a read of the soft-power status, and separately with a write-one to the PME status, on the exact same edge. A design that let the clear win would lose that ring event, and a later read would show zero. It also keeps the ring input low across a clear. A level-sensitive design would then set the status again at once. A write of zero to the PME status and reads of the PME register are checked to leave the bit alone. Each request is followed as its enable is removed and as its status clears, which exposes any request that is latched instead of gated.

// File: rtl/ring_wake_pkg.sv
package ring_wake_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_SP_STS  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_SP_EN   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_SMI_EN  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PME_STS = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_PME_EN  = 3'd4;

  localparam int SP_BIT  = 3;
  localparam int SMI_BIT = 0;
  localparam int PME_BIT = 5;

  localparam int N_REQ   = 3;
  localparam int REQ_PWR = 0;
  localparam int REQ_SMI = 1;
  localparam int REQ_PME = 2;
endpackage

// File: rtl/ring_fall_detect.sv
module ring_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_n_i,
  output logic fall_o
);
  logic synced;
  logic prev_q;

  generate
    if (STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b1;
        else     s_q <= ring_n_i;
      end
      assign synced = s_q;
    end else begin : g_many
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '1;
        else     s_q <= {s_q[STAGES-2:0], ring_n_i};
      end
      assign synced = s_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= synced;
  end

  assign fall_o = prev_q & ~synced;

  // R1: an event lasts exactly one cycle, so a held level cannot re-set status
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sticky_status_bit.sv
module sticky_status_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk) begin
    if (rst)        sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
    else if (clr_i) sts_o <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> sts_o);
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !sts_o);
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(sts_o));
endmodule

// File: rtl/ring_reg_bank.sv
module ring_reg_bank
  import ring_wake_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [REG_DATA_W-1:0] wdata_i,
  input  logic                  sp_sts_i,
  input  logic                  pme_sts_i,
  output logic                  sp_en_o,
  output logic                  smi_en_o,
  output logic                  pme_en_o,
  output logic                  sp_clr_o,
  output logic                  pme_clr_o,
  output logic [REG_DATA_W-1:0] rdata_o
);
  logic [REG_DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_en_o  <= 1'b0;
      smi_en_o <= 1'b0;
      pme_en_o <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_SP_EN:  sp_en_o  <= wdata_i[SP_BIT];
        ADDR_SMI_EN: smi_en_o <= wdata_i[SMI_BIT];
        ADDR_PME_EN: pme_en_o <= wdata_i[PME_BIT];
        default: ;
      endcase
    end
  end

  assign sp_clr_o  = rd_i && (addr_i == ADDR_SP_STS);
  assign pme_clr_o = wr_i && (addr_i == ADDR_PME_STS) && wdata_i[PME_BIT];

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_SP_STS:  rd_mux[SP_BIT]  = sp_sts_i;
      ADDR_SP_EN:   rd_mux[SP_BIT]  = sp_en_o;
      ADDR_SMI_EN:  rd_mux[SMI_BIT] = smi_en_o;
      ADDR_PME_STS: rd_mux[PME_BIT] = pme_sts_i;
      ADDR_PME_EN:  rd_mux[PME_BIT] = pme_en_o;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i > ADDR_PME_EN) |=> (rdata_o == '0));
  assert_sp_en_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_SP_EN) |=> (sp_en_o == $past(wdata_i[SP_BIT])));
  assert_pme_en_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_PME_EN) |=> (pme_en_o == $past(wdata_i[PME_BIT])));
endmodule

// File: rtl/ring_req_gen.sv
module ring_req_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_o[g] <= 1'b0;
      else     req_o[g] <= sts_i[g] & en_i[g];
    end

    // R7 R8 R9: a request rises only from an enabled status and falls once either drops
    assert_req_gated_R7: assert property (@(posedge clk) disable iff (rst)
      !(sts_i[g] && en_i[g]) |=> !req_o[g]);
    assert_req_raised_R9: assert property (@(posedge clk) disable iff (rst)
      (sts_i[g] && en_i[g]) |=> req_o[g]);
  end
endmodule

// File: rtl/ring_wake_status.sv
module ring_wake_status
  import ring_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ring_n_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [REG_DATA_W-1:0] reg_wdata_i,
  output logic [REG_DATA_W-1:0] reg_rdata_o,
  output logic                  pwr_on_req_o,
  output logic                  smi_req_o,
  output logic                  pme_req_o
);
  logic ring_evt;
  logic sp_sts, pme_sts;
  logic sp_en, smi_en, pme_en;
  logic sp_clr, pme_clr;
  logic [N_REQ-1:0] req_sts, req_en, req_q;

  ring_fall_detect #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .ring_n_i(ring_n_i), .fall_o(ring_evt)
  );

  sticky_status_bit sp_sts_i (
    .clk(clk), .rst(rst), .set_i(ring_evt), .clr_i(sp_clr), .sts_o(sp_sts)
  );

  sticky_status_bit pme_sts_i (
    .clk(clk), .rst(rst), .set_i(ring_evt), .clr_i(pme_clr), .sts_o(pme_sts)
  );

  ring_reg_bank regs_i (
    .clk(clk), .rst(rst),
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i), .wdata_i(reg_wdata_i),
    .sp_sts_i(sp_sts), .pme_sts_i(pme_sts),
    .sp_en_o(sp_en), .smi_en_o(smi_en), .pme_en_o(pme_en),
    .sp_clr_o(sp_clr), .pme_clr_o(pme_clr),
    .rdata_o(reg_rdata_o)
  );

  always_comb begin
    req_sts          = '0;
    req_en           = '0;
    req_sts[REQ_PWR] = sp_sts;
    req_en[REQ_PWR]  = sp_en;
    req_sts[REQ_SMI] = pme_sts;
    req_en[REQ_SMI]  = smi_en;
    req_sts[REQ_PME] = pme_sts;
    req_en[REQ_PME]  = pme_en;
  end

  ring_req_gen #(.N(N_REQ)) req_i (
    .clk(clk), .rst(rst), .sts_i(req_sts), .en_i(req_en), .req_o(req_q)
  );

  assign pwr_on_req_o = req_q[REQ_PWR];
  assign smi_req_o    = req_q[REQ_SMI];
  assign pme_req_o    = req_q[REQ_PME];

  // R5: writes never clear the read-cleared status
  assert_sp_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (sp_sts && !reg_rd_i) |=> sp_sts);
  // R4: reads never clear the write-one-cleared status
  assert_pme_read_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (pme_sts && !reg_wr_i) |=> pme_sts);
  // R8: SMI and PME requests share one status source
  assert_smi_shares_status_R8: assert property (@(posedge clk) disable iff (rst)
    smi_req_o |-> $past(pme_sts));
endmodule

// File: tb/ring_wake_status_tb_top.sv
module ring_wake_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ring_n = 1'b1;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwr_req, smi_req, pme_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_wake_status #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .ring_n_i(ring_n),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .pwr_on_req_o(pwr_req), .smi_req_o(smi_req), .pme_req_o(pme_req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ring_pulse();
    @(negedge clk); ring_n = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    ring_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    reg_read(3'd0, d);
    reg_write(3'd3, 8'h20);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 pwr req after reset", {7'd0, pwr_req}, 8'h0);
    chk("R11 smi req after reset", {7'd0, smi_req}, 8'h0);
    chk("R11 pme req after reset", {7'd0, pme_req}, 8'h0);
    chk("R11 rdata after reset", rdata, 8'h0);
    reg_read(3'd0, d); chk("R11 sp status after reset", d, 8'h00);
    reg_read(3'd3, d); chk("R11 pme status after reset", d, 8'h00);
    reg_read(3'd1, d); chk("R11 sp enable after reset", d, 8'h00);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    reg_write(3'd1, 8'hFF); reg_read(3'd1, d); chk("R6 sp enable readback", d, 8'h08);
    reg_write(3'd2, 8'hFF); reg_read(3'd2, d); chk("R6 smi enable readback", d, 8'h01);
    reg_write(3'd4, 8'hFF); reg_read(3'd4, d); chk("R6 pme enable readback", d, 8'h20);
    reg_write(3'd1, 8'hF7); reg_read(3'd1, d); chk("R6 sp enable cleared", d, 8'h00);
    reg_write(3'd2, 8'h00); reg_write(3'd4, 8'h00);
  endtask

  task automatic t_latch_without_enable();
    logic [7:0] d;
    ring_pulse();
    chk("R2 no pwr req when disabled", {7'd0, pwr_req}, 8'h0);
    chk("R2 no pme req when disabled", {7'd0, pme_req}, 8'h0);
    reg_read(3'd3, d); chk("R2 pme status latched", d, 8'h20);
    reg_read(3'd3, d); chk("R4 pme read does not clear", d, 8'h20);
    reg_read(3'd0, d); chk("R2 sp status latched", d, 8'h08);
    reg_read(3'd0, d); chk("R3 sp status cleared by read", d, 8'h00);
  endtask

  task automatic t_pme_w1c();
    logic [7:0] d;
    ring_pulse();
    reg_write(3'd3, 8'hDF); reg_read(3'd3, d); chk("R4 write zero keeps pme", d, 8'h20);
    reg_write(3'd0, 8'hFF); reg_read(3'd0, d); chk("R5 write does not clear sp", d, 8'h08);
    reg_write(3'd3, 8'h20); reg_read(3'd3, d); chk("R4 write one clears pme", d, 8'h00);
  endtask

  task automatic t_level_held();
    logic [7:0] d;
    @(negedge clk); ring_n = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    reg_read(3'd0, d); chk("R1 falling edge sets sp", d, 8'h08);
    reg_write(3'd3, 8'h20);
    repeat (3) @(negedge clk);
    reg_read(3'd0, d); chk("R1 held low does not re-set sp", d, 8'h00);
    reg_read(3'd3, d); chk("R1 held low does not re-set pme", d, 8'h00);
    ring_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    reg_read(3'd3, d); chk("R1 rising edge does not set", d, 8'h00);
  endtask

  task automatic t_requests();
    logic [7:0] d;
    reg_write(3'd1, 8'h08);
    reg_write(3'd2, 8'h01);
    reg_write(3'd4, 8'h20);
    ring_pulse();
    chk("R7 pwr req raised", {7'd0, pwr_req}, 8'h1);
    chk("R8 smi req raised", {7'd0, smi_req}, 8'h1);
    chk("R9 pme req raised", {7'd0, pme_req}, 8'h1);
    reg_write(3'd4, 8'h00); @(negedge clk);
    chk("R9 pme req drops with enable", {7'd0, pme_req}, 8'h0);
    chk("R8 smi req stays", {7'd0, smi_req}, 8'h1);
    reg_write(3'd3, 8'h20); @(negedge clk);
    chk("R8 smi req drops with pme status", {7'd0, smi_req}, 8'h0);
    chk("R7 pwr req stays", {7'd0, pwr_req}, 8'h1);
    reg_read(3'd0, d); @(negedge clk);
    chk("R7 pwr req drops after read clear", {7'd0, pwr_req}, 8'h0);
    reg_write(3'd1, 8'h00); reg_write(3'd2, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk); ring_n = 1'b0;
    repeat (SYNC) @(negedge clk);
    addr = 3'd0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R10 read at event edge returns old", rdata, 8'h00);
    reg_read(3'd0, d); chk("R10 sp set wins over read clear", d, 8'h08);
    ring_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    reg_write(3'd3, 8'h20);
    @(negedge clk); ring_n = 1'b0;
    repeat (SYNC) @(negedge clk);
    addr = 3'd3; wdata = 8'h20; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    reg_read(3'd3, d); chk("R10 pme set wins over write clear", d, 8'h20);
    ring_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    clear_all();
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    reg_write(3'd5, 8'hFF); reg_write(3'd6, 8'hFF); reg_write(3'd7, 8'hFF);
    reg_read(3'd5, d); chk("R12 addr 5 reads zero", d, 8'h00);
    reg_read(3'd7, d); chk("R12 addr 7 reads zero", d, 8'h00);
    reg_read(3'd1, d); chk("R12 unmapped write leaves sp enable", d, 8'h00);
    reg_read(3'd4, d); chk("R12 unmapped write leaves pme enable", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enables();
    t_latch_without_enable();
    t_pme_w1c();
    clear_all();
    t_level_held();
    t_requests();
    t_set_wins();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule